// File: doc/BRIEF.md
# Bit-Serial PHY Tuning Writer

This block loads multi-bit tuning values into a PHY whose internal tuning cells are addressed one bit at a time. All traffic goes through a single shared control word. The word holds a bit address field, one data bit and a write strobe for each port. A request names a port, a starting bit address, a value of up to eight bits and a bit count. The block then walks the value out, least significant bit first. Each bit gets its own address and its own strobe pulse. While it works the block holds `busy`, and it pulses `done` when the last bit has been written.

A bit-addressed cell array sits behind the control word as a model of the PHY. It latches the data bit on the rising edge of a port's strobe. Its read port lets a user confirm what was written. Typical uses are the start-up tuning writes (termination trim, amplitude/rate, disconnect threshold) and turning squelch detection on or off, which is a two-bit write where 0 enables and 2 disables.

Top module: `phy_tune_writer`

## Requirements
- R1: After reset, `ctrl_word` is 0, `busy` and `done` are low, and every model cell reads 0.
- R2: A request is taken only in a cycle where `busy` is low. A `req_valid` pulse during a transfer is dropped completely and causes no strobe, no cell change and no extra `done`.
- R3: For bit j of a request, the address field `ctrl_word[15:8]` holds (start + j) mod 256 and `ctrl_word[7]` holds bit j of the value. Bits go out least significant first.
- R4: The strobe for port N is `ctrl_word[2*N]`. Only the requesting port's strobe ever rises, bits 1, 3 and 5 stay 0, and at most one strobe is high at a time.
- R5: Each bit takes exactly 5 cycles, in this order: load address, drop strobe, set data bit, raise strobe, drop strobe. The strobe is high for exactly one cycle, and the address and data fields do not change in the cycle the strobe rises.
- R6: With `CLEAR_FIRST`=1, the whole control word reads 0 in the cycle after a request with a nonzero length is accepted, before the first address is loaded.
- R7: `done` is high for one cycle, one cycle after the last strobe falls. For n bits it first reads high 2+5n clock edges after the accepting edge. `busy` is high from the accepting edge until `done` and is low while `done` is high.
- R8: A request with a length of 0 raises `done` in the cycle right after acceptance. `busy` never rises and no strobe rises.
- R9: A length above 8 is treated as 8, and cells past the eighth address are left unchanged.
- R10: The model cell at (port, address) takes the data bit only on a rising edge of that port's strobe. `rd_bit` shows the cell selected by `rd_port`/`rd_addr`. Cells of other ports and other addresses keep their values.
- R11: The tuning writes produce these readbacks: 1 at 0x0C, value 0x14 over 0x20..0x24, value 3 or 2 over 0x2A..0x2B. A squelch write of 2 at 0x3C gives 0x3C=0 and 0x3D=1, and a write of 0 clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request pulse, taken while idle |
| req_port | input | 2 | Target PHY port |
| req_addr | input | 8 | Starting bit address |
| req_data | input | 8 | Value to write, LSB first |
| req_len | input | 4 | Number of bits, 0 to 8, larger values clamped |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| ctrl_word | output | 16 | Shared control word: address [15:8], data [7], strobes at even bits |
| rd_port | input | 2 | Model readback port select |
| rd_addr | input | 8 | Model readback bit address |
| rd_bit | output | 1 | Model cell value |

## Verification
The main path is driven with the real tuning patterns on two ports: a single-bit write, a five-bit sparse value (0x14) and two-bit values that differ only in bit 0. These show whether the bit order is correct and whether one port's strobe can leak into another port's cells. A squelch disable followed by an enable overwrites cells that are already set, which tells edge capture apart from sticky or OR-style writes. A start address of 0xFE separates wrapping address arithmetic from saturating arithmetic. Lengths of 0 and 12 exercise the two edges of the length handling, and a request injected mid-transfer shows whether the idle gating holds.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Bit positions inside the shared control word that the PHY decodes.
  localparam int DATA_BIT_POS = 7;
  localparam int ADDR_LSB     = 8;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WIPE     = 3'd1,
    ST_ADDR     = 3'd2,
    ST_STB_LOW  = 3'd3,
    ST_DATA     = 3'd4,
    ST_STB_HIGH = 3'd5,
    ST_STB_DROP = 3'd6,
    ST_FIN      = 3'd7
  } ptw_step_e;

endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/ptw_seq.sv
module ptw_seq
  import ptw_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int CLEAR_FIRST = 1,
  localparam int PORT_W     = $clog2(NUM_PORTS),
  localparam int LEN_W      = $clog2(DATA_W) + 1,
  localparam int CW_W       = ADDR_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PORT_W-1:0] req_port,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              done,
  output logic [CW_W-1:0]   ctrl_word
);

  localparam int IDX_W = $clog2(CW_W);

  ptw_step_e         state_q, state_d;
  logic [PORT_W-1:0] port_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [LEN_W-1:0]  remain_q, remain_d;
  logic [CW_W-1:0]   ctrl_q, ctrl_d;
  logic              done_q, done_d;
  logic [LEN_W-1:0]  len_eff;
  logic [IDX_W-1:0]  stb_idx;
  logic              ld_req, ctx_en, ctrl_en;

  assign len_eff = (req_len > LEN_W'(DATA_W)) ? LEN_W'(DATA_W) : req_len;
  assign stb_idx = IDX_W'({port_q, 1'b0});
  assign ld_req  = (state_q == ST_IDLE) && req_valid;
  assign ctx_en  = ld_req || (state_q == ST_STB_DROP);

  // Context for the next bit: either a fresh request or one bit further on.
  always_comb begin
    addr_d   = ld_req ? req_addr : addr_q + 1'b1;
    data_d   = ld_req ? req_data : (data_q >> 1);
    remain_d = ld_req ? len_eff  : remain_q - 1'b1;
  end

  always_comb begin
    state_d = state_q;
    ctrl_d  = ctrl_q;
    ctrl_en = 1'b0;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (len_eff == '0) begin
            done_d = 1'b1;
          end else begin
            state_d = (CLEAR_FIRST != 0) ? ST_WIPE : ST_ADDR;
          end
        end
      end
      ST_WIPE: begin
        ctrl_en = 1'b1;
        ctrl_d  = '0;
        state_d = ST_ADDR;
      end
      ST_ADDR: begin
        ctrl_en = 1'b1;
        ctrl_d[ADDR_LSB +: ADDR_W] = addr_q;
        state_d = ST_STB_LOW;
      end
      ST_STB_LOW: begin
        ctrl_en = 1'b1;
        ctrl_d[stb_idx] = 1'b0;
        state_d = ST_DATA;
      end
      ST_DATA: begin
        ctrl_en = 1'b1;
        ctrl_d[DATA_BIT_POS] = data_q[0];
        state_d = ST_STB_HIGH;
      end
      ST_STB_HIGH: begin
        ctrl_en = 1'b1;
        ctrl_d[stb_idx] = 1'b1;
        state_d = ST_STB_DROP;
      end
      ST_STB_DROP: begin
        ctrl_en = 1'b1;
        ctrl_d[stb_idx] = 1'b0;
        state_d = (remain_q == LEN_W'(1)) ? ST_FIN : ST_ADDR;
      end
      ST_FIN: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      done_q   <= 1'b0;
      ctrl_q   <= '0;
      port_q   <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      remain_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (ctrl_en) begin
        ctrl_q <= ctrl_d;
      end
      if (ld_req) begin
        port_q <= req_port;
      end
      if (ctx_en) begin
        addr_q   <= addr_d;
        data_q   <= data_d;
        remain_q <= remain_d;
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign ctrl_word = ctrl_q;

endmodule

// File: rtl/ptw_bitfile.sv
module ptw_bitfile
  import ptw_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int CW_W     = ADDR_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW_W-1:0]   ctrl_word,
  input  logic [PORT_W-1:0] rd_port,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0]    wr_addr;
  logic                 wr_bit;
  logic [NUM_PORTS-1:0] stb_now, stb_prev_q;
  logic [DEPTH-1:0]     bank [NUM_PORTS];
  logic                 unused_ctrl;

  assign wr_addr     = ctrl_word[ADDR_LSB +: ADDR_W];
  assign wr_bit      = ctrl_word[DATA_BIT_POS];
  assign unused_ctrl = ^ctrl_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_prev_q <= '0;
    end else begin
      stb_prev_q <= stb_now;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic             rise;
    logic [DEPTH-1:0] cells_q;

    assign stb_now[p] = ctrl_word[2*p];
    assign rise       = stb_now[p] && !stb_prev_q[p];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cells_q <= '0;
      end else if (rise) begin
        cells_q[wr_addr] <= wr_bit;
      end
    end

    assign bank[p] = cells_q;
  end

  assign rd_bit = bank[rd_port][rd_addr];

endmodule

// File: rtl/phy_tune_writer.sv
module phy_tune_writer #(
  parameter int NUM_PORTS   = 4,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int CLEAR_FIRST = 1,
  localparam int PORT_W     = $clog2(NUM_PORTS),
  localparam int LEN_W      = $clog2(DATA_W) + 1,
  localparam int CW_W       = ADDR_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PORT_W-1:0] req_port,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              done,
  output logic [CW_W-1:0]   ctrl_word,
  input  logic [PORT_W-1:0] rd_port,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit
);

  logic rst_sync_n;

  ptw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ptw_seq #(
    .NUM_PORTS   (NUM_PORTS),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .CLEAR_FIRST (CLEAR_FIRST)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_port  (req_port),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .req_len   (req_len),
    .busy      (busy),
    .done      (done),
    .ctrl_word (ctrl_word)
  );

  ptw_bitfile #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W)
  ) u_cells (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctrl_word (ctrl_word),
    .rd_port   (rd_port),
    .rd_addr   (rd_addr),
    .rd_bit    (rd_bit)
  );

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int NUM_PORTS = 4,
  parameter int CW_W      = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CW_W-1:0] ctrl_word,
  input logic            busy,
  input logic            done
);

  function automatic logic [6:0] strobe_mask();
    logic [6:0] m;
    m = '0;
    for (int i = 0; i < NUM_PORTS; i++) m[2*i] = 1'b1;
    return m;
  endfunction

  localparam logic [6:0] STB_MASK = strobe_mask();

  logic [NUM_PORTS-1:0] stb;
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_stb
    assign stb[p] = ctrl_word[2*p];
  end

  AST_SPARE_BITS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[6:0] & ~STB_MASK) == 7'd0); // R4

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb)); // R4

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb) |=> !(|stb)); // R5

  AST_FIELDS_HELD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|stb) |-> $stable(ctrl_word[CW_W-1:7])); // R5

  AST_DONE_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(|stb)); // R8

endmodule

bind phy_tune_writer ptw_checker #(
  .NUM_PORTS (NUM_PORTS),
  .CW_W      (CW_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ctrl_word (ctrl_word),
  .busy      (busy),
  .done      (done)
);

// File: tb/phy_tune_writer_tb.sv
module phy_tune_writer_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_port;
  logic [7:0]  req_addr;
  logic [7:0]  req_data;
  logic [3:0]  req_len;
  logic        busy;
  logic        done;
  logic [15:0] ctrl_word;
  logic [1:0]  rd_port;
  logic [7:0]  rd_addr;
  logic        rd_bit;

  int n_chk;
  int n_fail;
  bit finished;

  phy_tune_writer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_port  (req_port),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .req_len   (req_len),
    .busy      (busy),
    .done      (done),
    .ctrl_word (ctrl_word),
    .rd_port   (rd_port),
    .rd_addr   (rd_addr),
    .rd_bit    (rd_bit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Strobe monitor, sampled at the falling edge.
  logic [15:0] prev_ctrl;
  int          rise_cnt [4];
  logic [7:0]  log_addr [32];
  logic        log_dat  [32];
  int          log_n;

  initial prev_ctrl = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < 4; p++) begin
        if (ctrl_word[2*p] && !prev_ctrl[2*p]) begin
          rise_cnt[p]++;
          if (log_n < 32) begin
            log_addr[log_n] = ctrl_word[15:8];
            log_dat[log_n]  = ctrl_word[7];
          end
          log_n++;
          n_chk++;
          if (prev_ctrl[15:7] !== ctrl_word[15:7]) begin
            n_fail++;
            $display("FAIL R5 fields moved at strobe rise: actual %h expected %h",
                     ctrl_word[15:7], prev_ctrl[15:7]);
          end
        end
        if (ctrl_word[2*p] && prev_ctrl[2*p]) begin
          n_chk++;
          n_fail++;
          $display("FAIL R5 strobe %0d high two cycles: actual 1 expected 0", p);
        end
      end
      if (ctrl_word[1] | ctrl_word[3] | ctrl_word[5]) begin
        n_chk++;
        n_fail++;
        $display("FAIL R4 odd control bits: actual %h expected 0", ctrl_word[5:1]);
      end
    end
    prev_ctrl = ctrl_word;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rb(input logic [1:0] p, input logic [7:0] a, output logic b);
    rd_port = p;
    rd_addr = a;
    #1;
    b = rd_bit;
  endtask

  task automatic clear_log();
    log_n = 0;
    for (int q = 0; q < 4; q++) rise_cnt[q] = 0;
  endtask

  // Issue one request and check timing, fields and strobe routing.
  task automatic do_write(input logic [1:0] p, input logic [7:0] a,
                          input logic [7:0] d, input logic [3:0] n);
    int          cyc;
    int          ne;
    logic [15:0] c1, c2;
    logic        b1;
    ne = (n > 8) ? 8 : int'(n);
    @(negedge clk);
    req_port  = p;
    req_addr  = a;
    req_data  = d;
    req_len   = n;
    req_valid = 1'b1;
    clear_log();
    cyc = 0; c1 = '0; c2 = '0; b1 = 1'b0;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      cyc++;
      if (cyc == 1) begin c1 = ctrl_word; b1 = busy; end
      if (cyc == 2) c2 = ctrl_word;
    end while (!done && cyc < 300);
    chk("R7 cycles to done", cyc, (ne == 0) ? 1 : 3 + 5 * ne);
    chk("R7 busy low with done", busy, 0);
    if (ne > 0) begin
      chk("R7 busy after accept", b1, 1);
      if (c1 != 0) chk("R6 word wiped before first bit", c2, 0);
    end else begin
      chk("R8 zero length never busy", b1, 0);
    end
    for (int q = 0; q < 4; q++) begin
      chk((q == p) ? "R5 one strobe per bit" : "R4 foreign strobe", rise_cnt[q],
          (q == p) ? ne : 0);
    end
    for (int j = 0; j < ne; j++) begin
      chk("R3 address field", log_addr[j], 8'(a + j));
      chk("R3 data bit", log_dat[j], d[j]);
    end
    @(negedge clk);
    chk("R7 done single cycle", done, 0);
  endtask

  task automatic expect_bit(input string tag, input logic [1:0] p,
                            input logic [7:0] a, input logic e);
    logic b;
    rb(p, a, b);
    chk(tag, b, e);
  endtask

  task automatic t_reset();
    chk("R1 ctrl after reset", ctrl_word, 0);
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);
    expect_bit("R1 cell after reset", 0, 8'h0C, 0);
    expect_bit("R1 cell after reset", 3, 8'h3C, 0);
  endtask

  task automatic t_tuning_port0();
    do_write(0, 8'h0C, 8'h01, 1);
    do_write(0, 8'h20, 8'h14, 5);
    do_write(0, 8'h2A, 8'h03, 2);
    expect_bit("R11 trim bit", 0, 8'h0C, 1);
    for (int j = 0; j < 5; j++) expect_bit("R11 amplitude bits", 0, 8'(8'h20 + j), 1'((8'h14 >> j) & 1));
    expect_bit("R11 threshold bit0", 0, 8'h2A, 1);
    expect_bit("R11 threshold bit1", 0, 8'h2B, 1);
    expect_bit("R10 neighbour untouched", 0, 8'h25, 0);
  endtask

  task automatic t_tuning_port1();
    do_write(1, 8'h20, 8'h14, 5);
    do_write(1, 8'h2A, 8'h02, 2);
    expect_bit("R11 port1 threshold bit0", 1, 8'h2A, 0);
    expect_bit("R11 port1 threshold bit1", 1, 8'h2B, 1);
    expect_bit("R11 port1 amplitude bit2", 1, 8'h22, 1);
    expect_bit("R10 port0 kept", 0, 8'h2A, 1);
    expect_bit("R10 port1 trim untouched", 1, 8'h0C, 0);
  endtask

  task automatic t_squelch();
    do_write(3, 8'h3C, 8'h02, 2);
    expect_bit("R11 squelch off bit0", 3, 8'h3C, 0);
    expect_bit("R11 squelch off bit1", 3, 8'h3D, 1);
    do_write(3, 8'h3C, 8'h00, 2);
    expect_bit("R10 squelch on overwrites", 3, 8'h3D, 0);
    expect_bit("R11 squelch on bit0", 3, 8'h3C, 0);
  endtask

  task automatic t_zero_len();
    do_write(2, 8'h10, 8'hFF, 0);
    expect_bit("R8 no cell written", 2, 8'h10, 0);
  endtask

  task automatic t_clamp();
    do_write(2, 8'h80, 8'hA5, 4'd12);
    for (int j = 0; j < 8; j++) expect_bit("R9 clamped bits", 2, 8'(8'h80 + j), 1'((8'hA5 >> j) & 1));
    expect_bit("R9 past eighth bit", 2, 8'h88, 0);
    expect_bit("R9 past eighth bit", 2, 8'h8B, 0);
  endtask

  task automatic t_wrap();
    do_write(2, 8'hFE, 8'h0B, 4);
    expect_bit("R3 wrap 0xFE", 2, 8'hFE, 1);
    expect_bit("R3 wrap 0xFF", 2, 8'hFF, 1);
    expect_bit("R3 wrap 0x00", 2, 8'h00, 0);
    expect_bit("R3 wrap 0x01", 2, 8'h01, 1);
  endtask

  task automatic t_busy_ignore();
    int cyc;
    int dones;
    @(negedge clk);
    req_port = 1; req_addr = 8'h40; req_data = 8'hFF; req_len = 3;
    req_valid = 1'b1;
    clear_log();
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      req_valid = (cyc == 3);
      if (cyc == 3) begin
        req_port = 2; req_addr = 8'h50; req_data = 8'hFF; req_len = 8;
      end
    end while (!done && cyc < 300);
    chk("R2 cycles unaffected", cyc, 18);
    dones = 0;
    repeat (3) begin
      @(negedge clk);
      if (done) dones++;
      chk("R2 no late start", busy, 0);
    end
    chk("R2 no extra done", dones, 0);
    chk("R2 no port2 strobe", rise_cnt[2], 0);
    for (int j = 0; j < 8; j++) expect_bit("R2 port2 cells untouched", 2, 8'(8'h50 + j), 0);
    for (int j = 0; j < 3; j++) expect_bit("R2 port1 cells written", 1, 8'(8'h40 + j), 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    clear_log();
    rst_n = 1'b0; req_valid = 1'b0; req_port = '0; req_addr = '0;
    req_data = '0; req_len = '0; rd_port = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_tuning_port0();
    t_tuning_port1();
    t_squelch();
    t_zero_len();
    t_clamp();
    t_wrap();
    t_busy_ignore();
    repeat (2) @(negedge clk);
    summary();
  end

endmodule